// File: doc/BRIEF.md
# Receive Buffer Ring Fetch Engine

This block keeps track of the receive buffer that a network receiver is currently filling. The buffers are listed in a circular table in memory. Each table entry holds the 32-bit base address of one buffer and the buffer's size in 16-bit words. On request, the engine reads one entry over a simple word-wide memory read port and loads it as the current buffer. It then moves its table read pointer forward by one entry. The pointer returns to the table start when it reaches the table end. When the pointer catches up with the write pointer that the host owns, the engine raises a sticky exhausted flag.

A fetch starts in one of three ways. The host issues a fetch command. The host clears the exhausted flag. Or a received frame leaves less room in the current buffer than a programmable threshold. After each frame the engine moves the base address past the frame and its 4-byte CRC and reduces the remaining word count to match. A request that arrives while a fetch is running is held and served as soon as that fetch ends. The engine also reports whether the receiver may accept frames.

Top module: `rra_engine`

## Requirements
- R1: After reset, read_ptr, buf_base and buf_words are zero, and exhausted, last_pkt, cmd_active, fetch_busy and mem_req are all low.
- R2: A fetch reads the four entry words at {upper_addr, read_ptr} + i*2 bytes when wide_mode is 0, or + i*4 bytes when wide_mode is 1 (i = 0..3). The data is in mem_rdata[15:0]. When the fetch ends, buf_base = {word1, word0} and buf_words = {word3, word2}.
- R3: After each fetch, read_ptr has moved forward by the entry stride: 8 when wide_mode is 0, 16 when wide_mode is 1.
- R4: If the advanced pointer equals ring_end, read_ptr is loaded with ring_start instead.
- R5: If the final read_ptr of a fetch equals write_ptr, exhausted is set. It stays set until exh_clear is pulsed.
- R6: cmd_fetch sets cmd_active and starts a fetch. cmd_active returns low in the cycle after that fetch ends.
- R7: exh_clear while exhausted is set clears the flag and starts a fetch. exh_clear while the flag is low changes nothing, and no fetch starts.
- R8: A frame_done pulse with frame_len = N adds N+4 to buf_base and subtracts (N+4)/2 (rounded down) from buf_words.
- R9: After a frame, last_pkt shows whether the new buf_words is below eob_count. When it is, a fetch starts in the next cycle. When it is not, no fetch starts.
- R10: can_accept is high only when rx_enable is high and exhausted is low.
- R11: A fetch request that arrives during a fetch is served right after the current fetch, so both entries are consumed.
- R12: Bit 0 of the read pointer, ring_start, ring_end and write_ptr is always treated as 0. A host write of an odd value to the read pointer stores it with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | 1: 32-bit memory words (16-byte entries); 0: 16-bit (8-byte entries) |
| upper_addr | input | 16 | Upper half of the table address |
| ring_start | input | 16 | Lower address of the table start |
| ring_end | input | 16 | Lower address one past the table end |
| write_ptr | input | 16 | Host-owned table write pointer |
| eob_count | input | 16 | Word-count threshold for last packet in buffer |
| rp_wr_en | input | 1 | Host write strobe for the read pointer |
| rp_wr_data | input | 16 | Value for the read pointer |
| cmd_fetch | input | 1 | Fetch command pulse |
| exh_clear | input | 1 | Host clear of the exhausted flag |
| rx_enable | input | 1 | Receiver enabled |
| frame_done | input | 1 | One received frame has been stored |
| frame_len | input | 16 | Byte length of that frame, without CRC |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted; mem_rdata valid this cycle |
| mem_rdata | input | 16 | Read data |
| read_ptr | output | 16 | Table read pointer |
| buf_base | output | 32 | Current buffer base address |
| buf_words | output | 32 | Remaining words in current buffer |
| cmd_active | output | 1 | Fetch command outstanding |
| fetch_busy | output | 1 | Fetch sequence running |
| exhausted | output | 1 | Table exhausted flag |
| last_pkt | output | 1 | Last frame left the buffer below threshold |
| can_accept | output | 1 | Receiver may accept a frame |

## Verification
The assertions take four things for granted about the environment. mem_ack rises only while mem_req is high. frame_done is never pulsed while a fetch is running. The host writes the read pointer only while the engine is idle. upper_addr and the table registers do not change during a fetch.

The stimulus respects all four. The bench memory acknowledges only requests that are present, and a stall control only holds the acknowledge back. Frames, pointer writes and table set-ups are applied only after fetch_busy has been seen low.

The table sweeps cover both word widths, table sizes from two to five entries, and every write-pointer position. Under these conditions wrap and exhaustion arise on their own.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int PTR_W       = 16;
  localparam int WORD_W      = 16;
  localparam int ADDR_W      = 2 * WORD_W;
  localparam int ENTRY_WORDS = 4;
  localparam int IDX_W       = $clog2(ENTRY_WORDS);
  localparam int CRC_BYTES   = 4;

  typedef enum logic {SEQ_IDLE, SEQ_READ} seq_state_e;

  // byte distance between two table entries
  function automatic logic [PTR_W-1:0] entry_stride(input logic wide);
    return wide ? PTR_W'(ENTRY_WORDS * 4) : PTR_W'(ENTRY_WORDS * 2);
  endfunction

  // pointer value after consuming one entry, with wrap
  function automatic logic [PTR_W-1:0] ptr_after_fetch(input logic [PTR_W-1:0] rp,
                                                       input logic wide,
                                                       input logic [PTR_W-1:0] first,
                                                       input logic [PTR_W-1:0] last);
    logic [PTR_W-1:0] adv;
    adv = rp + entry_stride(wide);
    return (adv == last) ? first : adv;
  endfunction

  // byte address of one word of the entry at rp
  function automatic logic [ADDR_W-1:0] entry_word_addr(input logic [WORD_W-1:0] upper,
                                                        input logic [PTR_W-1:0] rp,
                                                        input logic [IDX_W-1:0] idx,
                                                        input logic wide);
    logic [ADDR_W-1:0] ofs;
    ofs = wide ? (ADDR_W'(idx) << 2) : (ADDR_W'(idx) << 1);
    return {upper, rp} + ofs;
  endfunction

  // buffer words consumed by a frame plus its CRC
  function automatic logic [ADDR_W-1:0] frame_words(input logic [WORD_W-1:0] len);
    return (ADDR_W'(len) + ADDR_W'(CRC_BYTES)) >> 1;
  endfunction
endpackage

// File: rtl/rra_fetch_seq.sv
module rra_fetch_seq
  import rra_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                wide,
  input  logic [WORD_W-1:0]   upper,
  input  logic [PTR_W-1:0]    rp,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   ent_base,
  output logic [ADDR_W-1:0]   ent_count
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_WORDS - 1);

  seq_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic               pend;
  logic [WORD_W-1:0]  held [ENTRY_WORDS-1];
  logic               last_beat;

  assign busy      = (state == SEQ_READ);
  assign mem_req   = busy;
  assign mem_addr  = entry_word_addr(upper, rp, idx, wide);
  assign last_beat = busy && mem_ack && (idx == LAST_IDX);
  assign done      = last_beat;
  assign ent_base  = {held[1], held[0]};
  assign ent_count = {mem_rdata, held[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      idx   <= '0;
      pend  <= 1'b0;
    end else if (state == SEQ_IDLE) begin
      if (start_req) begin
        state <= SEQ_READ;
        idx   <= '0;
      end
    end else if (last_beat) begin
      idx  <= '0;
      pend <= 1'b0;
      if (!(pend || start_req)) state <= SEQ_IDLE;
    end else begin
      if (mem_ack) idx <= idx + 1'b1;
      if (start_req) pend <= 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRY_WORDS - 1; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[g] <= '0;
      else if (busy && mem_ack && idx == IDX_W'(g)) held[g] <= mem_rdata;
    end
  end

  // environment: acknowledge only an outstanding request
  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> mem_req);
  // held request is served right after the current fetch
  assert_pending_served_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (pend || start_req)) |=> mem_req);
endmodule

// File: rtl/rra_ptr_unit.sv
module rra_ptr_unit
  import rra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic [PTR_W-1:0]  first,
  input  logic [PTR_W-1:0]  last,
  input  logic [PTR_W-1:0]  wp,
  input  logic              host_wr,
  input  logic [PTR_W-1:0]  host_data,
  input  logic              fetch_done,
  input  logic              exh_clear,
  output logic [PTR_W-1:0]  read_ptr,
  output logic              exhausted,
  output logic              exh_hit
);
  logic [PTR_W-1:0] nxt;

  assign nxt     = ptr_after_fetch(read_ptr, wide, first, last);
  assign exh_hit = exh_clear && exhausted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_ptr  <= '0;
      exhausted <= 1'b0;
    end else begin
      if (host_wr)         read_ptr <= host_data & ~PTR_W'(1);
      else if (fetch_done) read_ptr <= nxt;
      if (fetch_done && nxt == wp) exhausted <= 1'b1;
      else if (exh_clear)          exhausted <= 1'b0;
    end
  end

  assert_ptr_even_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !read_ptr[0]);
  // step by one stride, or land on the table start after wrap
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !host_wr) |=>
      ((read_ptr == $past(first)) ||
       (read_ptr - $past(read_ptr) == ($past(wide) ? PTR_W'(16) : PTR_W'(8)))));
  assert_exh_from_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exhausted) |-> $past(fetch_done));
endmodule

// File: rtl/rra_buf_track.sv
module rra_buf_track
  import rra_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  ent_base,
  input  logic [ADDR_W-1:0]  ent_count,
  input  logic               frame_done,
  input  logic [WORD_W-1:0]  frame_len,
  input  logic [WORD_W-1:0]  eob,
  output logic [ADDR_W-1:0]  buf_base,
  output logic [ADDR_W-1:0]  buf_words,
  output logic               last_pkt,
  output logic               refill_req
);
  logic [ADDR_W-1:0] words_after;
  logic              below;

  assign words_after = buf_words - frame_words(frame_len);
  assign below       = words_after < ADDR_W'(eob);
  assign refill_req  = frame_done && below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_base  <= '0;
      buf_words <= '0;
      last_pkt  <= 1'b0;
    end else if (load) begin
      buf_base  <= ent_base;
      buf_words <= ent_count;
    end else if (frame_done) begin
      buf_base  <= buf_base + ADDR_W'(frame_len) + ADDR_W'(CRC_BYTES);
      buf_words <= words_after;
      last_pkt  <= below;
    end
  end

  assert_base_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !load) |=>
      (buf_base - $past(buf_base) == ADDR_W'($past(frame_len)) + ADDR_W'(4)));
  assert_lastpkt_from_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_pkt) |-> $past(frame_done));
endmodule

// File: rtl/rra_engine.sv
module rra_engine
  import rra_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic [WORD_W-1:0]  upper_addr,
  input  logic [PTR_W-1:0]   ring_start,
  input  logic [PTR_W-1:0]   ring_end,
  input  logic [PTR_W-1:0]   write_ptr,
  input  logic [WORD_W-1:0]  eob_count,
  input  logic               rp_wr_en,
  input  logic [PTR_W-1:0]   rp_wr_data,
  input  logic               cmd_fetch,
  input  logic               exh_clear,
  input  logic               rx_enable,
  input  logic               frame_done,
  input  logic [WORD_W-1:0]  frame_len,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [PTR_W-1:0]   read_ptr,
  output logic [ADDR_W-1:0]  buf_base,
  output logic [ADDR_W-1:0]  buf_words,
  output logic               cmd_active,
  output logic               fetch_busy,
  output logic               exhausted,
  output logic               last_pkt,
  output logic               can_accept
);
  localparam logic [PTR_W-1:0] EVEN_MASK = ~PTR_W'(1);

  logic              fetch_done;
  logic              exh_hit;
  logic              refill_req;
  logic              start_req;
  logic [ADDR_W-1:0] ent_base;
  logic [ADDR_W-1:0] ent_count;

  assign start_req  = cmd_fetch || exh_hit || refill_req;
  assign can_accept = rx_enable && !exhausted;

  rra_fetch_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .wide      (wide_mode),
    .upper     (upper_addr),
    .rp        (read_ptr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (fetch_busy),
    .done      (fetch_done),
    .ent_base  (ent_base),
    .ent_count (ent_count)
  );

  rra_ptr_unit u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide_mode),
    .first      (ring_start & EVEN_MASK),
    .last       (ring_end & EVEN_MASK),
    .wp         (write_ptr & EVEN_MASK),
    .host_wr    (rp_wr_en),
    .host_data  (rp_wr_data),
    .fetch_done (fetch_done),
    .exh_clear  (exh_clear),
    .read_ptr   (read_ptr),
    .exhausted  (exhausted),
    .exh_hit    (exh_hit)
  );

  rra_buf_track u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (fetch_done),
    .ent_base   (ent_base),
    .ent_count  (ent_count),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .eob        (eob_count),
    .buf_base   (buf_base),
    .buf_words  (buf_words),
    .last_pkt   (last_pkt),
    .refill_req (refill_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_active <= 1'b0;
    else if (cmd_fetch)  cmd_active <= 1'b1;
    else if (fetch_done) cmd_active <= 1'b0;
  end

  assert_cmd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !cmd_fetch) |=> !cmd_active);
  // environment: frames are not reported while an entry is being loaded
  assert_no_frame_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !fetch_busy);
  assert_exh_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !can_accept);
endmodule

// File: tb/sim_rra_engine.sv
module sim_rra_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] upper_addr = 16'h0012;
  logic [15:0] ring_start = '0, ring_end = '0, write_ptr = '0, eob_count = '0;
  logic        rp_wr_en = 1'b0;
  logic [15:0] rp_wr_data = '0;
  logic        cmd_fetch = 1'b0, exh_clear = 1'b0, rx_enable = 1'b0;
  logic        frame_done = 1'b0;
  logic [15:0] frame_len = '0;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] read_ptr;
  logic [31:0] buf_base, buf_words;
  logic        cmd_active, fetch_busy, exhausted, last_pkt, can_accept;

  logic        ack_en = 1'b1;
  logic        ovr_en = 1'b0;
  logic [31:0] ovr_base = '0;
  logic [15:0] ovr_word [4];

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C5A;
  endfunction

  function automatic logic [31:0] waddr(input logic [15:0] rp, input int i, input logic w);
    return {upper_addr, rp} + 32'(i * (w ? 4 : 2));
  endfunction

  always_comb begin
    logic [31:0] ofs;
    ofs = mem_addr - ovr_base;
    mem_ack = mem_req && ack_en;
    if (ovr_en && ofs < (wide_mode ? 32'd16 : 32'd8))
      mem_rdata = ovr_word[wide_mode ? ofs[3:2] : ofs[2:1]];
    else
      mem_rdata = mem_fn(mem_addr);
  end

  rra_engine u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic pulse_cmd();
    cmd_fetch = 1'b1;
    @(negedge clk) cmd_fetch = 1'b0;
  endtask

  task automatic pulse_clr();
    exh_clear = 1'b1;
    @(negedge clk) exh_clear = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 200 && fetch_busy; t++) @(negedge clk);
  endtask

  task automatic host_rp(input logic [15:0] v);
    rp_wr_en = 1'b1; rp_wr_data = v;
    @(negedge clk) rp_wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rp_m, st, stv, wpv;
    logic        exh_m;
    logic [31:0] base_m, words_m, used;

    @(negedge clk);
    // R1 reset state
    chk("R1 read_ptr", 32'(read_ptr), 0);
    chk("R1 buf_base", buf_base, 0);
    chk("R1 buf_words", buf_words, 0);
    chk("R1 flags", {27'b0, exhausted, last_pkt, cmd_active, fetch_busy, mem_req}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R12 odd host pointer write
    host_rp(16'h0123);
    chk("R12 masked pointer", 32'(read_ptr), 32'h0122);

    // table sweep: R2 R3 R4 R5 R6 R7
    for (int w = 0; w < 2; w++) begin
      for (int n = 2; n <= 5; n++) begin
        for (int k = 0; k < n; k++) begin
          do_reset();
          wide_mode = w[0];
          st = w[0] ? 16'd16 : 16'd8;
          stv = 16'h0400;
          ring_start = stv;
          ring_end = stv + 16'(n) * st;
          wpv = stv + 16'(k) * st;
          write_ptr = wpv;
          host_rp(stv);
          rp_m = stv; exh_m = 1'b0;
          for (int j = 0; j <= n; j++) begin
            if (exh_m) pulse_clr(); else pulse_cmd();
            chk("R6 busy after request", {31'b0, fetch_busy}, 1);
            if (!exh_m) chk("R6 cmd_active set", {31'b0, cmd_active}, 1);
            chk("R7 clear drops flag", {31'b0, exhausted}, 0);
            wait_idle();
            chk("R2 base", buf_base, {mem_fn(waddr(rp_m, 1, w[0])), mem_fn(waddr(rp_m, 0, w[0]))});
            chk("R2 words", buf_words, {mem_fn(waddr(rp_m, 3, w[0])), mem_fn(waddr(rp_m, 2, w[0]))});
            rp_m = rp_m + st;
            if (rp_m == ring_end) rp_m = stv;   // R4 wrap
            exh_m = (rp_m == wpv);
            chk("R3 R4 pointer", 32'(read_ptr), 32'(rp_m));
            chk("R5 exhausted", {31'b0, exhausted}, {31'b0, exh_m});
            chk("R6 cmd_active cleared", {31'b0, cmd_active}, 0);
          end
        end
      end
    end

    // R10 can_accept truth table; ensure exhausted set now
    do_reset();
    wide_mode = 1'b0; ring_start = 16'h0200; ring_end = 16'h0210; write_ptr = 16'h0208;
    host_rp(16'h0200);
    for (int e = 0; e < 2; e++) begin
      for (int r = 0; r < 2; r++) begin
        rx_enable = r[0];
        @(negedge clk);
        chk("R10 can_accept", {31'b0, can_accept}, {31'b0, r[0] && !exhausted});
      end
      if (e == 0) begin pulse_cmd(); wait_idle(); chk("R5 set for R10", {31'b0, exhausted}, 1); end
    end

    // R7 exh_clear without the flag does nothing
    do_reset();
    ring_start = 16'h0200; ring_end = 16'h0240; write_ptr = 16'h0230;
    host_rp(16'h0200);
    pulse_clr();
    chk("R7 no fetch on idle clear", {31'b0, fetch_busy}, 0);
    repeat (6) @(negedge clk);
    chk("R7 pointer unchanged", 32'(read_ptr), 32'h0200);

    // R11 request during a fetch
    ack_en = 1'b0;
    pulse_cmd();
    pulse_cmd();
    repeat (3) @(negedge clk);
    chk("R11 stalled busy", {31'b0, fetch_busy}, 1);
    ack_en = 1'b1;
    wait_idle();
    chk("R11 two entries consumed", 32'(read_ptr), 32'h0210);

    // R8 R9 frames against a known entry
    do_reset();
    wide_mode = 1'b0; ring_start = 16'h0300; ring_end = 16'h0340; write_ptr = 16'h0338;
    eob_count = 16'd100;
    host_rp(16'h0300);
    ovr_en = 1'b1; ovr_base = {upper_addr, 16'h0300};
    ovr_word[0] = 16'h2340; ovr_word[1] = 16'h0001; ovr_word[2] = 16'h0100; ovr_word[3] = 16'h0000;
    pulse_cmd(); wait_idle();
    chk("R2 override base", buf_base, 32'h00012340);
    base_m = 32'h00012340; words_m = 32'h100;
    ovr_base = {upper_addr, 16'h0308};
    foreach (ovr_word[i]) ovr_word[i] = ovr_word[i];
    for (int f = 0; f < 4; f++) begin
      logic [15:0] len;
      logic        low;
      case (f)
        0: len = 16'd60;
        1: len = 16'd61;
        2: len = 16'd300;
        default: len = 16'd10;
      endcase
      used = (32'(len) + 32'd4) >> 1;
      base_m = base_m + 32'(len) + 32'd4;
      words_m = words_m - used;
      low = words_m < 32'(eob_count);
      frame_len = len; frame_done = 1'b1;
      @(negedge clk) frame_done = 1'b0;
      chk("R8 base advance", buf_base, base_m);
      chk("R8 words drop", buf_words, words_m);
      chk("R9 last_pkt", {31'b0, last_pkt}, {31'b0, low});
      chk("R9 refill start", {31'b0, fetch_busy}, {31'b0, low});
      if (low) begin
        wait_idle();
        chk("R9 refill loaded base", buf_base, 32'h00012340);
        chk("R9 refill pointer", 32'(read_ptr), 32'h0310);
        base_m = 32'h00012340; words_m = 32'h100;
      end
    end
    ovr_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule